// File: doc/BRIEF.md
# Capture-Compare PWM Timer

This block is a 16-bit timer/counter with a prescaled clock enable, two compare channels that each drive a waveform pin, and one capture channel fed by an external pin. Four counting modes are available: a free-running up count, a count that restarts after matching compare channel A, a sawtooth PWM, and a triangle PWM that counts up to the top and back down to zero. Every cycle, each compare channel checks its 16-bit value against the counter. A match raises that channel's flag. In the PWM modes the compare value sets the duty cycle of the output.

A small register port (address, write strobe, write data, combinational read data) holds the control fields, the counter, both compare values, the capture value and the flags. The capture value is read as two byte-wide halves. The capture pin is brought into the clock domain by a two-flop synchronizer and then edge-detected, with the active edge set by software. Flags are set by hardware. Software clears a flag by writing a one to it.

Top module: `tmr_capcmp_pwm`

## Requirements
- R1: After reset, every register reads zero: control, counter, both compare values, capture and flags. Both waveform pins are low. The counter is stopped.
- R2: Control bits [4:2] select the counter clock: 0 stops it, 1 advances it on every clock, and 2, 3, 4 and 5 advance it once every 8, 64, 256 and 1024 clocks. Codes 6 and 7 stop it. Every write to the control register restarts the divider, so with division N the first advance happens on the Nth clock edge after the write edge.
- R3: While the clock select stops the counter, its value does not change unless software writes it, and no compare or overflow event occurs.
- R4: With mode field bits [1:0] = 0 (normal), the counter counts up and wraps from 0xFFFF to 0. On an advance taken at 0xFFFF, overflow flag bit 0 is set. No other mode sets bit 0.
- R5: With mode = 1 (clear on match A), an advance taken while the counter equals compare A loads 0 in place of the next count.
- R6: With mode = 2 (sawtooth PWM), the counter counts up and wraps. On an advance, a channel's pin goes low if the counter equals its compare value. Otherwise the pin goes high if the counter is 0xFFFF.
- R7: With mode = 3 (triangle PWM), the counter counts up and, on the advance taken at 0xFFFF, steps to 0xFFFE and turns downward. Counting down, the advance taken at 0 steps to 1 and turns upward. On a matching advance, the channel pin goes low while counting up and high while counting down.
- R8: Flag bit 1 (channel A) or bit 2 (channel B) is set by any advance taken while the counter equals that channel's compare value. In modes 0 and 1, such a match toggles the channel pin.
- R9: A control write with bit 6 (channel A) or bit 7 (channel B) set toggles that channel's pin at once, with no match and no flag. This happens only if the mode in effect before the write is 0 or 1. In modes 2 and 3 the strobe has no effect. The strobe bits read back as zero.
- R10: Control bit 5 selects the capture edge (1 = rising, 0 = falling). On the third clock edge after the pin changes, the counter value at that moment is loaded into the capture register and flag bit 3 is set. The opposite edge does nothing. The low byte reads at address 4 and the high byte at address 5.
- R11: Writing address 6 clears each flag whose bit in the write data is one. A hardware set in the same cycle wins over the clear. Set flags stay set otherwise. The flags also appear on the flag output.
- R12: Register addresses are 0 control, 1 counter, 2 compare A, 3 compare B, 4/5 capture bytes, 6 flags. A counter write takes priority over an advance in the same cycle and suppresses that cycle's compare and overflow events. Compare writes take effect on the next comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| cap_pin | input | 1 | Asynchronous capture trigger pin |
| wave_a | output | 1 | Waveform output of compare channel A |
| wave_b | output | 1 | Waveform output of compare channel B |
| irq_flags | output | 4 | Flags: bit 0 overflow, 1 match A, 2 match B, 3 capture |

## Verification
The properties assume the capture pin holds each level for at least two clocks, so the synchronizer never sees an edge it could lose. They also assume software never sets a force strobe in the same cycle as a real match on that channel, because the two toggles would cancel. The stimulus holds the capture pin steady for several cycles between transitions. It applies force strobes only while the counter is stopped. Counter writes and compare writes always come from the register port at a falling edge, so they never race an advance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL = 2'd0,
    WM_CTC    = 2'd1,
    WM_FAST   = 2'd2,
    WM_PHASE  = 2'd3
  } wave_mode_e;

  localparam int ADDR_W  = 3;
  localparam int PRE_W   = 10;
  localparam int FLAG_W  = 4;
  localparam int NUM_CH  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAPH  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd6;

  localparam int FL_OVF = 0;
  localparam int FL_MA  = 1;
  localparam int FL_MB  = 2;
  localparam int FL_CAP = 3;

  localparam int CB_EDGE  = 5;
  localparam int CB_FORCE = 6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    pre_d = restart ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    case (sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q[PRE_W-1:0];
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  wave_mode_e       mode,
  input  logic [CNT_W-1:0] top_a,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             wrap_ev
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             dir_d;
  logic             adv;

  assign adv     = tick & ~load;
  assign wrap_ev = adv & (mode == WM_NORMAL) & (cnt == MAXV);

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_up;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      case (mode)
        WM_CTC:   cnt_d = (cnt == top_a) ? '0 : cnt + 1'b1;
        WM_PHASE: begin
          if (dir_up) begin
            if (cnt == MAXV) begin
              cnt_d = cnt - 1'b1;
              dir_d = 1'b0;
            end else begin
              cnt_d = cnt + 1'b1;
            end
          end else begin
            if (cnt == '0) begin
              cnt_d = cnt + 1'b1;
              dir_d = 1'b1;
            end else begin
              cnt_d = cnt - 1'b1;
            end
          end
        end
        default:  cnt_d = cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      dir_up <= dir_d;
    end
  end
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  wave_mode_e       mode,
  input  logic             dir_up,
  input  logic             force_pulse,
  output logic             match,
  output logic             wave
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic wave_d;

  assign match = adv & (cnt == cmp);

  always_comb begin
    wave_d = wave;
    case (mode)
      WM_FAST: begin
        if (match)                      wave_d = 1'b0;
        else if (adv && (cnt == MAXV))  wave_d = 1'b1;
      end
      WM_PHASE: begin
        if (match) wave_d = ~dir_up;
      end
      default: wave_d = wave ^ match ^ force_pulse;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= wave_d;
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rising,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_ev,
  output logic [CNT_W-1:0] cap_val
);
  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cap_d;

  assign cap_ev = rising ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);

  always_comb begin
    cap_d = cap_ev ? cnt : cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cap_val <= '0;
    end else begin
      sync_q  <= {sync_q[1:0], pin};
      cap_val <= cap_d;
    end
  end
endmodule

// File: rtl/tmr_capcmp_pwm.sv
module tmr_capcmp_pwm
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_pin,
  output logic              wave_a,
  output logic              wave_b,
  output logic [FLAG_W-1:0] irq_flags
);
  localparam int HALF = CNT_W / 2;

  logic [1:0]        rs_q;
  logic              rst_int_n;
  wave_mode_e        mode_q, mode_d;
  logic [2:0]        cs_q, cs_d;
  logic              edge_q, edge_d;
  logic [FLAG_W-1:0] flag_q, flag_d, flag_set, flag_clr;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_d [NUM_CH];
  logic [NUM_CH-1:0] match, wave, force_pulse;
  logic              wr_ctrl, wr_cnt, wr_flag;
  logic              tick, adv, dir_up, wrap_ev, cap_ev;
  logic [CNT_W-1:0]  cnt_q, cap_val;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_we && (reg_addr == A_COUNT);
  assign wr_flag = reg_we && (reg_addr == A_FLAG);
  assign adv     = tick & ~wr_cnt;

  always_comb begin
    mode_d = mode_q;
    cs_d   = cs_q;
    edge_d = edge_q;
    if (wr_ctrl) begin
      mode_d = wave_mode_e'(reg_wdata[1:0]);
      cs_d   = reg_wdata[4:2];
      edge_d = reg_wdata[CB_EDGE];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= WM_NORMAL;
      cs_q   <= '0;
      edge_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cs_q   <= cs_d;
      edge_q <= edge_d;
    end
  end

  tmr_prescaler i_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (wr_ctrl),
    .sel     (cs_q),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .mode     (mode_q),
    .top_a    (cmp_q[0]),
    .cnt      (cnt_q),
    .dir_up   (dir_up),
    .wrap_ev  (wrap_ev)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = A_CMPA + ADDR_W'(ch);

    assign force_pulse[ch] = wr_ctrl & reg_wdata[CB_FORCE+ch];

    always_comb begin
      cmp_d[ch] = (reg_we && (reg_addr == CH_ADDR)) ? reg_wdata : cmp_q[ch];
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) cmp_q[ch] <= '0;
      else            cmp_q[ch] <= cmp_d[ch];
    end

    tmr_cmp_channel #(.CNT_W(CNT_W)) i_chan (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .adv         (adv),
      .cnt         (cnt_q),
      .cmp         (cmp_q[ch]),
      .mode        (mode_q),
      .dir_up      (dir_up),
      .force_pulse (force_pulse[ch]),
      .match       (match[ch]),
      .wave        (wave[ch])
    );
  end

  tmr_capture #(.CNT_W(CNT_W)) i_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin     (cap_pin),
    .rising  (edge_q),
    .cnt     (cnt_q),
    .cap_ev  (cap_ev),
    .cap_val (cap_val)
  );

  assign flag_set = {cap_ev, match[1], match[0], wrap_ev};
  assign flag_clr = wr_flag ? reg_wdata[FLAG_W-1:0] : '0;

  always_comb begin
    flag_d = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flag_q <= '0;
    else            flag_q <= flag_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[5:0]      = {edge_q, cs_q, mode_q};
      A_COUNT: reg_rdata           = cnt_q;
      A_CMPA:  reg_rdata           = cmp_q[0];
      A_CMPB:  reg_rdata           = cmp_q[1];
      A_CAPL:  reg_rdata[HALF-1:0] = cap_val[HALF-1:0];
      A_CAPH:  reg_rdata[HALF-1:0] = cap_val[CNT_W-1:HALF];
      A_FLAG:  reg_rdata[FLAG_W-1:0] = flag_q;
      default: reg_rdata = '0;
    endcase
  end

  assign wave_a    = wave[0];
  assign wave_b    = wave[1];
  assign irq_flags = flag_q;
endmodule

// File: rtl/tmr_capcmp_pwm_chk.sv
module tmr_capcmp_pwm_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [2:0]        cs,
  input logic              tick,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic              dir_up,
  input logic [CNT_W-1:0]  cmp_a,
  input logic              cap_ev,
  input logic [CNT_W-1:0]  cap_val,
  input logic [FLAG_W-1:0] flags,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic stopped;
  assign stopped = (cs == 3'd0) || (cs > 3'd5);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cnt_wr) |=> $stable(cnt));

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && tick && !cnt_wr && cnt == MAXV) |=> flags[FL_OVF]);

  // R5
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && tick && !cnt_wr && cnt == cmp_a) |=> (cnt == '0));

  // R7
  phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && tick && !cnt_wr && dir_up && cnt == MAXV) |=> (cnt == MAXV - 1'b1 && !dir_up));

  // R10
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (cap_val == $past(cnt) && flags[FL_CAP]));

  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_CAP] && !(reg_we && reg_addr == A_FLAG && reg_wdata[FL_CAP])) |=> flags[FL_CAP]);
endmodule

bind tmr_capcmp_pwm tmr_capcmp_pwm_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .mode      (mode_q),
  .cs        (cs_q),
  .tick      (tick),
  .cnt_wr    (wr_cnt),
  .cnt       (cnt_q),
  .dir_up    (dir_up),
  .cmp_a     (cmp_q[0]),
  .cap_ev    (cap_ev),
  .cap_val   (cap_val),
  .flags     (flag_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/test_tmr_capcmp_pwm.sv
`timescale 1ns/1ps
module test_tmr_capcmp_pwm;
  logic        clk;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cap_pin;
  logic        wave_a;
  logic        wave_b;
  logic [3:0]  irq_flags;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  tmr_capcmp_pwm i_tmr_capcmp_pwm (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
    .wave_a(wave_a), .wave_b(wave_b), .irq_flags(irq_flags)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // behavioural reference model
  logic [15:0] m_cnt, m_cap;
  logic [15:0] m_cmp [2];
  logic [1:0]  m_wave;
  logic [3:0]  m_flags;
  logic [1:0]  m_mode;
  logic [2:0]  m_cs;
  logic        m_edge, m_up;
  int          m_pre;
  logic        m_s1, m_s2, m_s3;
  bit          t_tick, t_cw, t_ev, t_ov, t_ce;
  bit [1:0]    t_mt, t_fr;

  function automatic bit model_tick();
    int div;
    case (m_cs)
      3'd1: div = 1;
      3'd2: div = 8;
      3'd3: div = 64;
      3'd4: div = 256;
      3'd5: div = 1024;
      default: div = 0;
    endcase
    return (div != 0) && (((m_pre + 1) % div) == 0);
  endfunction

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {10'd0, m_edge, m_cs, m_mode};
      3'd1: return m_cnt;
      3'd2: return m_cmp[0];
      3'd3: return m_cmp[1];
      3'd4: return {8'd0, m_cap[7:0]};
      3'd5: return {8'd0, m_cap[15:8]};
      3'd6: return {12'd0, m_flags};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_cmp[0] = 0; m_cmp[1] = 0; m_wave = 0; m_flags = 0;
      m_mode = 0; m_cs = 0; m_edge = 0; m_up = 1; m_pre = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      t_tick = model_tick();
      t_cw   = reg_we && reg_addr == 3'd1;
      t_ev   = t_tick && !t_cw;
      for (int c = 0; c < 2; c++) begin
        t_mt[c] = t_ev && (m_cnt == m_cmp[c]);
        t_fr[c] = reg_we && reg_addr == 3'd0 && reg_wdata[6+c];
      end
      t_ov = t_ev && m_mode == 2'd0 && m_cnt == 16'hFFFF;
      t_ce = m_edge ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
      if (t_ce) m_cap = m_cnt;
      for (int c = 0; c < 2; c++) begin
        if (m_mode == 2'd2) begin
          if (t_mt[c]) m_wave[c] = 0;
          else if (t_ev && m_cnt == 16'hFFFF) m_wave[c] = 1;
        end else if (m_mode == 2'd3) begin
          if (t_mt[c]) m_wave[c] = !m_up;
        end else if (t_mt[c] != t_fr[c]) begin
          m_wave[c] = !m_wave[c];
        end
      end
      if (t_cw) m_cnt = reg_wdata;
      else if (t_tick) begin
        if (m_mode == 2'd1) m_cnt = (m_cnt == m_cmp[0]) ? 16'd0 : m_cnt + 16'd1;
        else if (m_mode == 2'd3) begin
          if (m_up && m_cnt == 16'hFFFF) begin m_cnt = 16'hFFFE; m_up = 0; end
          else if (!m_up && m_cnt == 0) begin m_cnt = 16'd1; m_up = 1; end
          else m_cnt = m_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
        end else m_cnt = m_cnt + 16'd1;
      end
      if (reg_we && reg_addr == 3'd6) m_flags = m_flags & ~reg_wdata[3:0];
      m_flags = m_flags | {t_ce, t_mt[1], t_mt[0], t_ov};
      if (reg_we && reg_addr == 3'd0) begin
        m_mode = reg_wdata[1:0]; m_cs = reg_wdata[4:2]; m_edge = reg_wdata[5]; m_pre = 0;
      end else m_pre = (m_pre + 1) % 1024;
      if (reg_we && reg_addr == 3'd2) m_cmp[0] = reg_wdata;
      if (reg_we && reg_addr == 3'd3) m_cmp[1] = reg_wdata;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk({cur_req, " pins/flags"}, {26'd0, wave_b, wave_a, irq_flags}, {26'd0, m_wave[1], m_wave[0], m_flags});
      chk({cur_req, " read data"}, {16'd0, reg_rdata}, {16'd0, model_read(reg_addr)});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic        w;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; cap_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (5) @(posedge clk);

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R1 register zero", {16'd0, d}, 32'd0);
    end
    chk("R1 pins low", {30'd0, wave_b, wave_a}, 32'd0);

    // R12 register map
    cur_req = "R12";
    wr(3'd2, 16'h0010); wr(3'd3, 16'h0020); wr(3'd1, 16'h1234);
    rd(3'd2, d); chk("R12 compare A", {16'd0, d}, 32'h0010);
    rd(3'd3, d); chk("R12 compare B", {16'd0, d}, 32'h0020);
    rd(3'd1, d); chk("R12 counter", {16'd0, d}, 32'h1234);
    wr(3'd0, 16'h00FF);
    rd(3'd0, d); chk("R12 R9 control readback, strobes read zero", {16'd0, d}, 32'h003F);
    wr(3'd0, 16'h0000);

    // R3 stopped counter
    cur_req = "R3";
    repeat (20) @(posedge clk);
    rd(3'd1, d); chk("R3 stopped count", {16'd0, d}, 32'h1234);
    wr(3'd0, 16'h0018);
    repeat (10) @(posedge clk);
    rd(3'd1, d); chk("R3 code 6 stops", {16'd0, d}, 32'h1234);

    // R2 prescaler
    cur_req = "R2";
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0008);
    reg_addr = 3'd1;
    repeat (80) @(posedge clk);
    #5 chk("R2 divide by 8", {16'd0, reg_rdata}, 32'd10);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd0, 16'h000C); repeat (200) @(posedge clk);
    wr(3'd0, 16'h0010); repeat (600) @(posedge clk);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0014);
    reg_addr = 3'd1;
    repeat (2048) @(posedge clk);
    #5 chk("R2 divide by 1024", {16'd0, reg_rdata}, 32'd2);

    // R4 R8 normal mode, R11 clear
    cur_req = "R4 R8";
    wr(3'd0, 16'h0000); wr(3'd6, 16'h000F);
    wr(3'd2, 16'hFFF8); wr(3'd3, 16'h0003); wr(3'd1, 16'hFFF0);
    wr(3'd0, 16'h0004);
    repeat (30) @(posedge clk);
    rd(3'd6, d); chk("R4 R8 overflow and match flags", {16'd0, d}, 32'h7);
    cur_req = "R11";
    wr(3'd6, 16'h0007);
    rd(3'd6, d); chk("R11 write-one clear", {16'd0, d}, 32'h0);
    wr(3'd0, 16'h0000);

    // R9 force strobe
    cur_req = "R9";
    w = wave_a;
    wr(3'd0, 16'h0040);
    chk("R9 force toggles A", {31'd0, wave_a}, {31'd0, ~w});
    rd(3'd6, d); chk("R9 no flag from force", {16'd0, d}, 32'h0);
    wr(3'd0, 16'h0002);
    w = wave_b;
    wr(3'd0, 16'h0082);
    chk("R9 force ignored in PWM", {31'd0, wave_b}, {31'd0, w});

    // R5 clear on match A
    cur_req = "R5";
    wr(3'd2, 16'h0005); wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0005);
    repeat (20) @(posedge clk);
    rd(3'd1, d); chk("R5 count stays within compare A", {31'd0, d <= 16'd5}, 32'd1);

    // R6 sawtooth PWM
    cur_req = "R6";
    wr(3'd0, 16'h0002);
    wr(3'd2, 16'h0004); wr(3'd3, 16'hFFFC); wr(3'd1, 16'hFFF8);
    wr(3'd0, 16'h0006);
    repeat (20) @(posedge clk);
    #5 chk("R6 pins after wrap", {30'd0, wave_b, wave_a}, 32'b10);

    // R7 triangle PWM
    cur_req = "R7";
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'hFFF8); wr(3'd3, 16'h0003); wr(3'd1, 16'hFFF0);
    wr(3'd0, 16'h0007);
    repeat (40) @(posedge clk);
    #5 chk("R7 A high after down match", {31'd0, wave_a}, 32'd1);
    wr(3'd1, 16'h0008);
    repeat (20) @(posedge clk);
    #5 chk("R7 B low after bottom turn", {31'd0, wave_b}, 32'd0);
    chk("R7 A unchanged", {31'd0, wave_a}, 32'd1);

    // R10 capture
    cur_req = "R10";
    wr(3'd0, 16'h0020); wr(3'd6, 16'h000F); wr(3'd1, 16'h1234);
    @(negedge clk) cap_pin = 1;
    repeat (5) @(posedge clk);
    rd(3'd4, d); chk("R10 capture low byte", {16'd0, d}, 32'h34);
    rd(3'd5, d); chk("R10 capture high byte", {16'd0, d}, 32'h12);
    rd(3'd6, d); chk("R10 capture flag", {16'd0, d}, 32'h8);
    wr(3'd6, 16'h000F);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h00AB);
    @(negedge clk) cap_pin = 0;
    repeat (5) @(posedge clk);
    rd(3'd4, d); chk("R10 falling capture", {16'd0, d}, 32'hAB);
    rd(3'd5, d); chk("R10 falling capture high", {16'd0, d}, 32'h00);
    wr(3'd6, 16'h000F); wr(3'd1, 16'h5555);
    @(negedge clk) cap_pin = 1;
    repeat (5) @(posedge clk);
    rd(3'd4, d); chk("R10 opposite edge ignored", {16'd0, d}, 32'hAB);
    rd(3'd6, d); chk("R10 no flag on opposite edge", {16'd0, d}, 32'h0);
    wr(3'd0, 16'h0024);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) cap_pin = ~cap_pin;
      repeat (7) @(posedge clk);
    end
    wr(3'd0, 16'h0000);
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule